// File: doc/BRIEF.md
# Configurable IO Pad Router

This block is the routing fabric that sits between a row of IO pad cells and the peripheral functions of a chip. Every pad cell has its own select input. The select value picks one function for that cell. The same choice routes the pad's input value to the chosen function and takes the pad's output value from it. It also decides which source drives the pad's output-enable, so one setting fixes both where a pad's signal goes and whether the pad drives.

Slot 0 of every cell is a general-purpose pin that belongs to that cell alone. It has an input, an output and a direction control, the same as any other peripheral. The remaining slots come from a shared pool of functions, laid out by a fixed table that is computed from the cell and slot numbers. Each pool function is input-only, output-only or bidirectional. A bidirectional function supplies its own output-enable. The router is purely combinational. Storage of the select values and any bus access sit outside it.

Top module: `pad_router`

## Requirements
- R1: With select 0 on a cell, the pad's output and output-enable equal that cell's general-purpose output and enable bits, and that cell's general-purpose input equals its pad input.
- R2: For select s in 1..NSLOTS-1, cell c connects to pool function (c + s - 1) mod NPOOL.
- R3: Pool function k is input-only when k mod 3 = 0, output-only when k mod 3 = 1, and bidirectional when k mod 3 = 2.
- R4: When a cell selects an output-only function k, the pad output is function k's output value and the pad output-enable is 1.
- R5: When a cell selects an input-only function, the pad output and output-enable are both 0, and function k's input receives the pad input.
- R6: When a cell selects a bidirectional function k, the pad output and output-enable are function k's output and enable bits, and function k's input receives the pad input.
- R7: A select value of NSLOTS or more drives the pad output and output-enable to 0.
- R8: A general-purpose input reads 0 while its cell's select is not 0. A pool function's input reads 0 while no cell selects it, and an output-only function's input always reads 0.
- R9: When several cells select the same pool function, that function's input comes from the lowest-numbered of those cells.
- R10: Every output follows its inputs combinationally, with no register and no clock on any path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sel | input | NCELLS*SELW | Per-cell select values, cell c at bits [c*SELW +: SELW] |
| pad_in | input | NCELLS | Input value received from each pad |
| pad_out | output | NCELLS | Output value sent to each pad |
| pad_oe | output | NCELLS | Output-enable sent to each pad |
| gpio_out | input | NCELLS | General-purpose output bit per cell |
| gpio_oe | input | NCELLS | General-purpose direction bit per cell (1 = drive) |
| gpio_in | output | NCELLS | General-purpose input bit per cell |
| fn_out | input | NPOOL | Output value of each pool function |
| fn_oe | input | NPOOL | Output-enable of each pool function (used when bidirectional) |
| fn_in | output | NPOOL | Input value delivered to each pool function |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero register stages. The bench therefore applies new select, pad and peripheral values on the falling clock edge. It compares all four output groups a quarter period later, well before the next rising edge. One directed case changes a pad input partway through a cycle and samples after a one-nanosecond delay with no clock edge in between. This shows that no path waits for a clock.

// File: rtl/pad_router_pkg.sv
package pad_router_pkg;

   typedef enum logic [1:0] {
      FK_IN    = 2'd0,
      FK_OUT   = 2'd1,
      FK_BIDIR = 2'd2
   } fn_kind_e;

   // direction class of a pool function
   function automatic fn_kind_e kind_of(input int k);
      case (k % 3)
         0:       return FK_IN;
         1:       return FK_OUT;
         default: return FK_BIDIR;
      endcase
   endfunction

   // pool function reached by cell c through slot s (s >= 1)
   function automatic int pool_of(input int c, input int s, input int npool);
      return (c + s - 1) % npool;
   endfunction

endpackage

// File: rtl/pad_out_sel.sv
module pad_out_sel
   import pad_router_pkg::*;
#(
   parameter int CELL   = 0,
   parameter int NPOOL  = 3,
   parameter int NSLOTS = 3,
   parameter int SELW   = 2
) (
   input  logic [SELW-1:0]  sel,
   input  logic             gpio_out,
   input  logic             gpio_oe,
   input  logic [NPOOL-1:0] fn_out,
   input  logic [NPOOL-1:0] fn_oe,
   output logic             pad_out,
   output logic             pad_oe
);
   localparam int NSEL = 1 << SELW;

   logic [NSEL-1:0] slot_out;
   logic [NSEL-1:0] slot_oe;

   for (genvar s = 0; s < NSEL; s++) begin : g_slot
      if (s == 0) begin : g_gpio
         assign slot_out[s] = gpio_out;
         assign slot_oe[s]  = gpio_oe;
      end else if (s < NSLOTS) begin : g_pool
         localparam int K = pool_of(CELL, s, NPOOL);
         localparam fn_kind_e KIND = kind_of(K);
         if (KIND == FK_OUT) begin : g_out
            assign slot_out[s] = fn_out[K];
            assign slot_oe[s]  = 1'b1;
         end else if (KIND == FK_IN) begin : g_in
            assign slot_out[s] = 1'b0;
            assign slot_oe[s]  = 1'b0;
         end else begin : g_bidir
            assign slot_out[s] = fn_out[K];
            assign slot_oe[s]  = fn_oe[K];
         end
      end else begin : g_zero
         assign slot_out[s] = 1'b0;
         assign slot_oe[s]  = 1'b0;
      end
   end

   assign pad_out = slot_out[sel];
   assign pad_oe  = slot_oe[sel];

endmodule

// File: rtl/fn_in_route.sv
module fn_in_route
   import pad_router_pkg::*;
#(
   parameter int FN     = 0,
   parameter int NCELLS = 4,
   parameter int NPOOL  = 3,
   parameter int NSLOTS = 3,
   parameter int SELW   = 2
) (
   input  logic [NCELLS*SELW-1:0] sel,
   input  logic [NCELLS-1:0]      pad_in,
   output logic                   fn_in
);
   localparam fn_kind_e KIND = kind_of(FN);

   if (KIND == FK_OUT) begin : g_noin
      assign fn_in = 1'b0;
   end else begin : g_route
      logic [NCELLS-1:0] hit;

      for (genvar c = 0; c < NCELLS; c++) begin : g_cell
         logic [NSLOTS-1:0] match;
         for (genvar s = 0; s < NSLOTS; s++) begin : g_s
            if (s > 0 && pool_of(c, s, NPOOL) == FN) begin : g_m
               assign match[s] = (sel[c*SELW +: SELW] == SELW'(s));
            end else begin : g_nm
               assign match[s] = 1'b0;
            end
         end
         assign hit[c] = |match;
      end

      always_comb begin
         fn_in = 1'b0;
         for (int c = NCELLS - 1; c >= 0; c--) begin
            if (hit[c]) fn_in = pad_in[c];
         end
      end
   end

endmodule

// File: rtl/pad_router.sv
module pad_router
   import pad_router_pkg::*;
#(
   parameter int NCELLS = 4,
   parameter int NPOOL  = 3,
   parameter int NSLOTS = 3,
   parameter int SELW   = 2
) (
   input  logic [NCELLS*SELW-1:0] sel,
   input  logic [NCELLS-1:0]      pad_in,
   output logic [NCELLS-1:0]      pad_out,
   output logic [NCELLS-1:0]      pad_oe,
   input  logic [NCELLS-1:0]      gpio_out,
   input  logic [NCELLS-1:0]      gpio_oe,
   output logic [NCELLS-1:0]      gpio_in,
   input  logic [NPOOL-1:0]       fn_out,
   input  logic [NPOOL-1:0]       fn_oe,
   output logic [NPOOL-1:0]       fn_in
);
   if (NCELLS < 1) begin : g_bad_cells
      $error("pad_router: NCELLS must be at least 1");
   end
   if (NPOOL < 1) begin : g_bad_pool
      $error("pad_router: NPOOL must be at least 1");
   end
   if (NSLOTS < 1 || NSLOTS > (1 << SELW)) begin : g_bad_slots
      $error("pad_router: NSLOTS must lie in 1..2**SELW");
   end

   for (genvar c = 0; c < NCELLS; c++) begin : g_cell
      pad_out_sel #(
         .CELL  (c),
         .NPOOL (NPOOL),
         .NSLOTS(NSLOTS),
         .SELW  (SELW)
      ) u_out (
         .sel     (sel[c*SELW +: SELW]),
         .gpio_out(gpio_out[c]),
         .gpio_oe (gpio_oe[c]),
         .fn_out  (fn_out),
         .fn_oe   (fn_oe),
         .pad_out (pad_out[c]),
         .pad_oe  (pad_oe[c])
      );
      assign gpio_in[c] = (sel[c*SELW +: SELW] == '0) ? pad_in[c] : 1'b0;
   end

   for (genvar k = 0; k < NPOOL; k++) begin : g_fn
      fn_in_route #(
         .FN    (k),
         .NCELLS(NCELLS),
         .NPOOL (NPOOL),
         .NSLOTS(NSLOTS),
         .SELW  (SELW)
      ) u_in (
         .sel   (sel),
         .pad_in(pad_in),
         .fn_in (fn_in[k])
      );
   end

endmodule

// File: rtl/pad_router_chk.sv
module pad_router_chk
   import pad_router_pkg::*;
#(
   parameter int NCELLS = 4,
   parameter int NPOOL  = 3,
   parameter int NSLOTS = 3,
   parameter int SELW   = 2
) (
   input logic [NCELLS*SELW-1:0] sel,
   input logic [NCELLS-1:0]      pad_in,
   input logic [NCELLS-1:0]      pad_out,
   input logic [NCELLS-1:0]      pad_oe,
   input logic [NCELLS-1:0]      gpio_out,
   input logic [NCELLS-1:0]      gpio_oe,
   input logic [NCELLS-1:0]      gpio_in,
   input logic [NPOOL-1:0]       fn_out,
   input logic [NPOOL-1:0]       fn_oe,
   input logic [NPOOL-1:0]       fn_in
);
   always_comb begin
      for (int c = 0; c < NCELLS; c++) begin
         int s;
         int k;
         s = int'(sel[c*SELW +: SELW]);
         k = pool_of(c, s, NPOOL);
         if (s == 0) begin
            assert_gpio_path_R1: assert (pad_out[c] == gpio_out[c] && pad_oe[c] == gpio_oe[c]
                                         && gpio_in[c] == pad_in[c]);
         end else begin
            assert_gpio_idle_R8: assert (gpio_in[c] == 1'b0);
         end
         if (s >= NSLOTS) begin
            assert_unassigned_zero_R7: assert (pad_out[c] == 1'b0 && pad_oe[c] == 1'b0);
         end else if (s > 0 && kind_of(k) == FK_OUT) begin
            assert_output_drives_R4: assert (pad_oe[c] == 1'b1 && pad_out[c] == fn_out[k]);
         end else if (s > 0 && kind_of(k) == FK_IN) begin
            assert_input_quiet_R5: assert (pad_oe[c] == 1'b0 && pad_out[c] == 1'b0);
         end else if (s > 0) begin
            assert_bidir_follows_R6: assert (pad_oe[c] == fn_oe[k] && pad_out[c] == fn_out[k]);
         end
      end
      for (int k = 0; k < NPOOL; k++) begin
         if (kind_of(k) == FK_OUT) begin
            assert_outonly_noin_R8: assert (fn_in[k] == 1'b0);
         end
      end
   end

endmodule

bind pad_router pad_router_chk #(
   .NCELLS(NCELLS),
   .NPOOL (NPOOL),
   .NSLOTS(NSLOTS),
   .SELW  (SELW)
) u_chk (
   .sel     (sel),
   .pad_in  (pad_in),
   .pad_out (pad_out),
   .pad_oe  (pad_oe),
   .gpio_out(gpio_out),
   .gpio_oe (gpio_oe),
   .gpio_in (gpio_in),
   .fn_out  (fn_out),
   .fn_oe   (fn_oe),
   .fn_in   (fn_in)
);

// File: tb/pad_router_test.sv
`timescale 1ns/1ps
module pad_router_test;
   localparam int NCELLS = 4;
   localparam int NPOOL  = 3;
   localparam int NSLOTS = 3;
   localparam int SELW   = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   logic [NCELLS*SELW-1:0] sel;
   logic [NCELLS-1:0] pad_in, pad_out, pad_oe, gpio_out, gpio_oe, gpio_in;
   logic [NPOOL-1:0]  fn_out, fn_oe, fn_in;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   pad_router #(.NCELLS(NCELLS), .NPOOL(NPOOL), .NSLOTS(NSLOTS), .SELW(SELW)) uut (
      .sel(sel), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe), .gpio_in(gpio_in),
      .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in)
   );

   function automatic int sel_of(input int c);
      return int'(sel[c*SELW +: SELW]);
   endfunction

   task automatic set_sel(input int c, input int v);
      sel[c*SELW +: SELW] = SELW'(v);
   endtask

   task automatic check(input string tag);
      logic [NCELLS-1:0] e_out, e_oe, e_gin;
      logic [NPOOL-1:0]  e_fin;
      for (int c = 0; c < NCELLS; c++) begin
         int s = sel_of(c);
         int k = (c + s - 1) % NPOOL;
         e_gin[c] = (s == 0) ? pad_in[c] : 1'b0;
         if (s == 0) begin
            e_out[c] = gpio_out[c]; e_oe[c] = gpio_oe[c];
         end else if (s >= NSLOTS || k % 3 == 0) begin
            e_out[c] = 1'b0; e_oe[c] = 1'b0;
         end else if (k % 3 == 1) begin
            e_out[c] = fn_out[k]; e_oe[c] = 1'b1;
         end else begin
            e_out[c] = fn_out[k]; e_oe[c] = fn_oe[k];
         end
      end
      for (int k = 0; k < NPOOL; k++) begin
         bit found = 0;
         e_fin[k] = 1'b0;
         if (k % 3 != 1) begin
            for (int c = 0; c < NCELLS; c++) begin
               int s = sel_of(c);
               if (!found && s >= 1 && s < NSLOTS && (c + s - 1) % NPOOL == k) begin
                  found = 1; e_fin[k] = pad_in[c];
               end
            end
         end
      end
      checks++;
      if (pad_out !== e_out || pad_oe !== e_oe || gpio_in !== e_gin || fn_in !== e_fin) begin
         fails++;
         $display("FAIL %s: out=%b oe=%b gin=%b fin=%b expected out=%b oe=%b gin=%b fin=%b",
                  tag, pad_out, pad_oe, gpio_in, fn_in, e_out, e_oe, e_gin, e_fin);
      end
   endtask

   task automatic settle_check(input string tag);
      #5;
      check(tag);
      @(negedge clk);
   endtask

   initial begin
      int unused;
      unused = $urandom(32'd1234);
      sel = '0; pad_in = '0; gpio_out = '0; gpio_oe = '0; fn_out = '0; fn_oe = '0;
      @(negedge clk);
      settle_check("R1 reset state");
      rst = 1'b0;

      // R1: all cells on their own general-purpose pin
      gpio_out = 4'b1010; gpio_oe = 4'b0110; pad_in = 4'b1100;
      settle_check("R1");

      // R7: every select beyond the assigned slots
      for (int c = 0; c < NCELLS; c++) set_sel(c, 3);
      fn_out = '1; fn_oe = '1;
      settle_check("R7");

      // R5/R3: cell0 slot1 -> pool0 (input-only)
      set_sel(0, 1); pad_in = 4'b0001;
      settle_check("R5 R3");

      // R4: cell1 slot1 -> pool1 (output-only)
      set_sel(1, 1); fn_out = 3'b010; fn_oe = 3'b000;
      settle_check("R4");

      // R6/R2: cell2 slot1 -> pool2 (bidirectional), cell0 slot2 -> pool1
      set_sel(2, 1); set_sel(0, 2); fn_out = 3'b100; fn_oe = 3'b000; pad_in = 4'b0100;
      settle_check("R6 R2");
      fn_oe = 3'b100;
      settle_check("R6");

      // R8: nobody selects pool0, output-only pool1 input stays 0
      sel = '0; set_sel(1, 1); pad_in = '1;
      settle_check("R8");

      // R9: cell0 slot1 and cell2 slot2 both reach pool0
      sel = '0; for (int c = 0; c < NCELLS; c++) set_sel(c, 3);
      set_sel(0, 1); set_sel(2, 2); pad_in = 4'b0100;
      settle_check("R9 low cell wins");
      pad_in = 4'b0001;
      settle_check("R9");

      // R10: change mid-cycle, sample with no clock edge in between
      #2; pad_in = 4'b0000; #1;
      check("R10 before");
      pad_in = 4'b0001; #1;
      check("R10");
      @(negedge clk);

      // random mix
      for (int i = 0; i < 400; i++) begin
         sel = NCELLS*SELW'($urandom); pad_in = NCELLS'($urandom);
         gpio_out = NCELLS'($urandom); gpio_oe = NCELLS'($urandom);
         fn_out = NPOOL'($urandom); fn_oe = NPOOL'($urandom);
         settle_check("R2 random");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule